// File: doc/BRIEF.md
# Queue Doorbell Decoder

This block sits behind the register write port of a multi-queue storage controller. It turns writes that land in the doorbell window into updates of two kinds of pointer. The first is the tail of a submission queue, written by the host after it places new commands. The second is the head of a completion queue, written by the host after it consumes completions. Every write is checked for alignment, for a valid queue index, for a queue that is present and for a pointer value that fits the queue. A write that fails any check is dropped without any side effect.

Per-queue configuration comes in from the queue-creation logic: a presence bit, a ring size and, for each submission queue, the completion queue it reports to. The block raises single-cycle strobes. One tells the submission-side scheduler that a queue has new work. Another wakes the completion poster when a full completion ring gains room. The last raises the interrupt of a completion queue that still holds unconsumed entries. When a head write relieves a full completion queue, every present submission queue bound to it is kicked as well, because those queues may have stalled for lack of completion space.

All pointer registers and strobes are registered. A write accepted at a clock edge is visible on the outputs from that edge until the next one.

Top module: `qdb_doorbell`

## Requirements
- R1: After reset every submission tail and completion head reads 0, and all kick and interrupt strobes are low.
- R2: A write to an address below the window base (default 0x1000) changes no pointer and raises no strobe.
- R3: A write whose address has bit 1 or bit 0 set changes no pointer and raises no strobe.
- R4: Within the window, with offset = address − base, offset bit 2 set selects a completion head doorbell and bit 2 clear selects a submission tail doorbell. The queue index is offset >> 3 in both cases.
- R5: A write is dropped if its queue index is not below NUM_Q or the addressed queue is not present.
- R6: Only data bits 15:0 form the new pointer. A value greater than or equal to the addressed queue's size is dropped, and no pointer of a present queue ever reaches its size.
- R7: An accepted submission tail write loads the tail and pulses sq_kick_o for that queue for exactly the one cycle after the write edge.
- R8: An accepted completion head write to a ring that was full just before the write pulses cq_kick_o for that queue. In the same cycle it pulses sq_kick_o for every present submission queue bound to it. A ring is full when (tail+1) mod size equals the old head.
- R9: An accepted completion head write pulses irq_o for that queue in the following cycle when the queue's tail differs from the new head. Otherwise no interrupt is raised.
- R10: The pointer of a queue that is not present reads 0 from the clock edge after its presence bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the write |
| data_i | input | DATA_W | Write data; bits 15:0 carry the pointer |
| sq_exist_i | input | NUM_Q | Submission queue present, one bit per queue |
| sq_size_i | input | NUM_Q*16 | Submission ring sizes in entries, 16 bits per queue |
| sq_cq_i | input | NUM_Q*QID_W | Completion queue index each submission queue reports to |
| cq_exist_i | input | NUM_Q | Completion queue present, one bit per queue |
| cq_size_i | input | NUM_Q*16 | Completion ring sizes in entries |
| cq_tail_i | input | NUM_Q*16 | Completion tail pointers maintained by the poster |
| sq_tail_o | output | NUM_Q*16 | Submission tail pointers |
| cq_head_o | output | NUM_Q*16 | Completion head pointers |
| sq_kick_o | output | NUM_Q | One-cycle strobe: submission queue has work to fetch |
| cq_kick_o | output | NUM_Q | One-cycle strobe: completion ring left the full state |
| irq_o | output | NUM_Q | One-cycle interrupt request per completion queue |

## Verification
The assertions assume that ring sizes stay fixed while a queue is present and that every ring is at least two entries. They also assume that the completion tail input of a present queue stays below its size, and that at most one write arrives per cycle. The stimulus sets sizes once before reset is released and never changes them. It changes completion tails only to values inside their rings and toggles only presence bits. Random addresses sweep a band across the window base and past the last queue. Pointer values are drawn near the ring sizes, so that dropped and accepted writes both occur often.

// File: rtl/qdb_pkg.sv
package qdb_pkg;

  localparam int PTR_W = 16;

  typedef enum logic [1:0] {
    DB_NONE    = 2'd0,
    DB_SQ_TAIL = 2'd1,
    DB_CQ_HEAD = 2'd2
  } db_kind_e;

  function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] ptr,
                                                 input logic [PTR_W-1:0] size);
    logic [PTR_W-1:0] inc;
    inc = ptr + PTR_W'(1);
    return (inc == size) ? '0 : inc;
  endfunction

  function automatic logic ring_full(input logic [PTR_W-1:0] tail,
                                     input logic [PTR_W-1:0] head,
                                     input logic [PTR_W-1:0] size);
    return ring_next(tail, size) == head;
  endfunction

endpackage

// File: rtl/qdb_addr_decode.sv
module qdb_addr_decode
  import qdb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_Q   = 64,
  parameter int DB_BASE = 'h1000,
  localparam int QID_W  = $clog2(NUM_Q)
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output db_kind_e          kind_o,
  output logic [QID_W-1:0]  qid_o
);

  logic              in_win;
  logic              aligned;
  logic              q_ok;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] wide_q;
  logic              unused_low;

  assign in_win     = addr_i >= ADDR_W'(DB_BASE);
  assign aligned    = addr_i[1:0] == 2'b00;
  assign offset     = addr_i - ADDR_W'(DB_BASE);
  assign wide_q     = offset >> 3;
  assign q_ok       = wide_q < ADDR_W'(NUM_Q);
  assign qid_o      = wide_q[QID_W-1:0];
  assign unused_low = ^offset[1:0];

  always_comb begin
    if (!wr_en_i || !in_win || !aligned || !q_ok) kind_o = DB_NONE;
    else if (offset[2])                            kind_o = DB_CQ_HEAD;
    else                                           kind_o = DB_SQ_TAIL;
  end

endmodule

// File: rtl/qdb_sq_ptrs.sv
module qdb_sq_ptrs
  import qdb_pkg::*;
#(
  parameter int NUM_Q  = 64,
  localparam int QID_W = $clog2(NUM_Q)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_Q-1:0]       exist_i,
  input  logic [NUM_Q*PTR_W-1:0] size_i,
  input  logic [NUM_Q*QID_W-1:0] cq_map_i,
  input  logic                   hit_i,
  input  logic [QID_W-1:0]       qid_i,
  input  logic [PTR_W-1:0]       val_i,
  input  logic                   wake_i,
  input  logic [QID_W-1:0]       wake_cq_i,
  output logic [NUM_Q*PTR_W-1:0] tail_o,
  output logic [NUM_Q-1:0]       kick_o,
  output logic                   accept_o
);

  logic [NUM_Q-1:0] sel;
  logic [NUM_Q-1:0] bound;
  logic [PTR_W-1:0] tail_q [NUM_Q];

  for (genvar j = 0; j < NUM_Q; j++) begin : g_q
    assign sel[j]   = hit_i && (qid_i == QID_W'(j)) && exist_i[j] &&
                      (val_i < size_i[j*PTR_W +: PTR_W]);
    assign bound[j] = wake_i && exist_i[j] &&
                      (cq_map_i[j*QID_W +: QID_W] == wake_cq_i);
    assign tail_o[j*PTR_W +: PTR_W] = tail_q[j];
  end

  assign accept_o = |sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kick_o <= '0;
      for (int j = 0; j < NUM_Q; j++) tail_q[j] <= '0;
    end else begin
      kick_o <= sel | bound;
      for (int j = 0; j < NUM_Q; j++) begin
        if (!exist_i[j])  tail_q[j] <= '0;
        else if (sel[j])  tail_q[j] <= val_i;
      end
    end
  end

endmodule

// File: rtl/qdb_cq_ptrs.sv
module qdb_cq_ptrs
  import qdb_pkg::*;
#(
  parameter int NUM_Q  = 64,
  localparam int QID_W = $clog2(NUM_Q)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_Q-1:0]       exist_i,
  input  logic [NUM_Q*PTR_W-1:0] size_i,
  input  logic [NUM_Q*PTR_W-1:0] tail_i,
  input  logic                   hit_i,
  input  logic [QID_W-1:0]       qid_i,
  input  logic [PTR_W-1:0]       val_i,
  output logic [NUM_Q*PTR_W-1:0] head_o,
  output logic [NUM_Q-1:0]       kick_o,
  output logic [NUM_Q-1:0]       irq_o,
  output logic                   accept_o,
  output logic                   wake_o,
  output logic [QID_W-1:0]       wake_cq_o
);

  logic [NUM_Q-1:0] sel;
  logic [NUM_Q-1:0] was_full;
  logic [NUM_Q-1:0] pending;
  logic [PTR_W-1:0] head_q [NUM_Q];

  for (genvar j = 0; j < NUM_Q; j++) begin : g_q
    assign sel[j]      = hit_i && (qid_i == QID_W'(j)) && exist_i[j] &&
                         (val_i < size_i[j*PTR_W +: PTR_W]);
    assign was_full[j] = ring_full(tail_i[j*PTR_W +: PTR_W], head_q[j],
                                   size_i[j*PTR_W +: PTR_W]);
    assign pending[j]  = tail_i[j*PTR_W +: PTR_W] != val_i;
    assign head_o[j*PTR_W +: PTR_W] = head_q[j];
  end

  assign accept_o  = |sel;
  assign wake_o    = |(sel & was_full);
  assign wake_cq_o = qid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kick_o <= '0;
      irq_o  <= '0;
      for (int j = 0; j < NUM_Q; j++) head_q[j] <= '0;
    end else begin
      kick_o <= sel & was_full;
      irq_o  <= sel & pending;
      for (int j = 0; j < NUM_Q; j++) begin
        if (!exist_i[j])  head_q[j] <= '0;
        else if (sel[j])  head_q[j] <= val_i;
      end
    end
  end

endmodule

// File: rtl/qdb_doorbell.sv
module qdb_doorbell
  import qdb_pkg::*;
#(
  parameter int NUM_Q   = 64,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int DB_BASE = 'h1000,
  localparam int QID_W  = $clog2(NUM_Q)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      data_i,
  input  logic [NUM_Q-1:0]       sq_exist_i,
  input  logic [NUM_Q*PTR_W-1:0] sq_size_i,
  input  logic [NUM_Q*QID_W-1:0] sq_cq_i,
  input  logic [NUM_Q-1:0]       cq_exist_i,
  input  logic [NUM_Q*PTR_W-1:0] cq_size_i,
  input  logic [NUM_Q*PTR_W-1:0] cq_tail_i,
  output logic [NUM_Q*PTR_W-1:0] sq_tail_o,
  output logic [NUM_Q*PTR_W-1:0] cq_head_o,
  output logic [NUM_Q-1:0]       sq_kick_o,
  output logic [NUM_Q-1:0]       cq_kick_o,
  output logic [NUM_Q-1:0]       irq_o
);

  db_kind_e          kind;
  logic [QID_W-1:0]  qid;
  logic [PTR_W-1:0]  wval;
  logic              sq_hit;
  logic              cq_hit;
  logic              sq_accept;
  logic              cq_accept;
  logic              wake_en;
  logic [QID_W-1:0]  wake_cq;
  logic              unused_data;

  assign wval        = data_i[PTR_W-1:0];
  assign unused_data = ^data_i;
  assign sq_hit      = kind == DB_SQ_TAIL;
  assign cq_hit      = kind == DB_CQ_HEAD;

  qdb_addr_decode #(.ADDR_W(ADDR_W), .NUM_Q(NUM_Q), .DB_BASE(DB_BASE)) u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .kind_o  (kind),
    .qid_o   (qid)
  );

  qdb_cq_ptrs #(.NUM_Q(NUM_Q)) u_cq (
    .clk       (clk),
    .rst_n     (rst_n),
    .exist_i   (cq_exist_i),
    .size_i    (cq_size_i),
    .tail_i    (cq_tail_i),
    .hit_i     (cq_hit),
    .qid_i     (qid),
    .val_i     (wval),
    .head_o    (cq_head_o),
    .kick_o    (cq_kick_o),
    .irq_o     (irq_o),
    .accept_o  (cq_accept),
    .wake_o    (wake_en),
    .wake_cq_o (wake_cq)
  );

  qdb_sq_ptrs #(.NUM_Q(NUM_Q)) u_sq (
    .clk       (clk),
    .rst_n     (rst_n),
    .exist_i   (sq_exist_i),
    .size_i    (sq_size_i),
    .cq_map_i  (sq_cq_i),
    .hit_i     (sq_hit),
    .qid_i     (qid),
    .val_i     (wval),
    .wake_i    (wake_en),
    .wake_cq_i (wake_cq),
    .tail_o    (sq_tail_o),
    .kick_o    (sq_kick_o),
    .accept_o  (sq_accept)
  );

endmodule

// File: rtl/qdb_doorbell_chk.sv
module qdb_doorbell_chk
  import qdb_pkg::*;
#(
  parameter int NUM_Q   = 64,
  parameter int ADDR_W  = 16,
  parameter int DB_BASE = 'h1000
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [NUM_Q-1:0]       sq_exist_i,
  input logic [NUM_Q*PTR_W-1:0] sq_size_i,
  input logic [NUM_Q-1:0]       cq_exist_i,
  input logic [NUM_Q*PTR_W-1:0] cq_size_i,
  input logic [NUM_Q*PTR_W-1:0] sq_tail_o,
  input logic [NUM_Q*PTR_W-1:0] cq_head_o,
  input logic [NUM_Q-1:0]       sq_kick_o,
  input logic [NUM_Q-1:0]       cq_kick_o,
  input logic [NUM_Q-1:0]       irq_o,
  input logic                   sq_accept,
  input logic                   cq_accept,
  input logic                   wake_en
);

  logic [NUM_Q-1:0] prev_sq_exist;
  logic [NUM_Q-1:0] prev_cq_exist;
  logic             bad_absent;
  logic             bad_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sq_exist <= '0;
      prev_cq_exist <= '0;
    end else begin
      prev_sq_exist <= sq_exist_i;
      prev_cq_exist <= cq_exist_i;
    end
  end

  always_comb begin
    bad_absent = 1'b0;
    bad_range  = 1'b0;
    for (int j = 0; j < NUM_Q; j++) begin
      if (!prev_sq_exist[j] && sq_tail_o[j*PTR_W +: PTR_W] != '0) bad_absent = 1'b1;
      if (!prev_cq_exist[j] && cq_head_o[j*PTR_W +: PTR_W] != '0) bad_absent = 1'b1;
      if (sq_exist_i[j] && sq_tail_o[j*PTR_W +: PTR_W] >= sq_size_i[j*PTR_W +: PTR_W])
        bad_range = 1'b1;
      if (cq_exist_i[j] && cq_head_o[j*PTR_W +: PTR_W] >= cq_size_i[j*PTR_W +: PTR_W])
        bad_range = 1'b1;
    end
  end

  assert_below_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && (addr_i < ADDR_W'(DB_BASE)) |=> (sq_kick_o == '0) && (cq_kick_o == '0) && (irq_o == '0));

  assert_unaligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && (addr_i[1:0] != 2'b00) |=> (sq_kick_o == '0) && (cq_kick_o == '0) && (irq_o == '0));

  assert_ptr_in_ring_R6: assert property (@(posedge clk) disable iff (!rst_n) !bad_range);

  assert_kick_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_kick_o != '0) |-> $past(sq_accept || wake_en));

  assert_wake_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cq_kick_o));

  assert_wake_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_kick_o != '0) |-> $past(wake_en));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0) |-> $onehot0(irq_o) && $past(cq_accept));

  assert_absent_zero_R10: assert property (@(posedge clk) disable iff (!rst_n) !bad_absent);

endmodule

bind qdb_doorbell qdb_doorbell_chk #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .DB_BASE(DB_BASE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .sq_exist_i (sq_exist_i),
  .sq_size_i  (sq_size_i),
  .cq_exist_i (cq_exist_i),
  .cq_size_i  (cq_size_i),
  .sq_tail_o  (sq_tail_o),
  .cq_head_o  (cq_head_o),
  .sq_kick_o  (sq_kick_o),
  .cq_kick_o  (cq_kick_o),
  .irq_o      (irq_o),
  .sq_accept  (sq_accept),
  .cq_accept  (cq_accept),
  .wake_en    (wake_en)
);

// File: tb/qdb_doorbell_tb.sv
module qdb_doorbell_tb;
  localparam int NQ = 64;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int QW = $clog2(NQ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [NQ-1:0] sq_ex = '0, cq_ex = '0;
  logic [NQ*16-1:0] sq_sz = '0, cq_sz = '0, cq_tl = '0;
  logic [NQ*QW-1:0] sq_map = '0;
  logic [NQ*16-1:0] sq_tail, cq_head;
  logic [NQ-1:0] sq_kick, cq_kick, irq;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // behavioural reference model
  int m_tail [NQ];
  int m_head [NQ];
  bit m_sqk [NQ];
  bit m_cqk [NQ];
  bit m_irq [NQ];

  always #2 clk = ~clk;

  qdb_doorbell u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .data_i(data),
    .sq_exist_i(sq_ex), .sq_size_i(sq_sz), .sq_cq_i(sq_map),
    .cq_exist_i(cq_ex), .cq_size_i(cq_sz), .cq_tail_i(cq_tl),
    .sq_tail_o(sq_tail), .cq_head_o(cq_head),
    .sq_kick_o(sq_kick), .cq_kick_o(cq_kick), .irq_o(irq)
  );

  function automatic int f16(input logic [NQ*16-1:0] v, input int j);
    return int'(v[j*16 +: 16]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < NQ; j++) begin
        m_tail[j] = 0; m_head[j] = 0; m_sqk[j] = 0; m_cqk[j] = 0; m_irq[j] = 0;
      end
    end else begin
      for (int j = 0; j < NQ; j++) begin m_sqk[j] = 0; m_cqk[j] = 0; m_irq[j] = 0; end
      if (wr_en && int'(addr) >= 4096 && int'(addr) % 4 == 0) begin
        int off, q, v;
        off = int'(addr) - 4096;
        q = off / 8;
        v = int'(data) & 'hffff;
        if (q < NQ) begin
          if ((off / 4) % 2 == 1) begin
            if (cq_ex[q] && v < f16(cq_sz, q)) begin
              int t, s;
              bit full;
              t = f16(cq_tl, q);
              s = f16(cq_sz, q);
              full = ((t + 1) % s) == m_head[q];
              m_head[q] = v;
              m_irq[q] = (t != v);
              if (full) begin
                m_cqk[q] = 1;
                for (int j = 0; j < NQ; j++)
                  if (sq_ex[j] && int'(sq_map[j*QW +: QW]) == q) m_sqk[j] = 1;
              end
            end
          end else if (sq_ex[q] && v < f16(sq_sz, q)) begin
            m_tail[q] = v;
            m_sqk[q] = 1;
          end
        end
      end
      for (int j = 0; j < NQ; j++) begin
        if (!sq_ex[j]) m_tail[j] = 0;
        if (!cq_ex[j]) m_head[j] = 0;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int j = 0; j < NQ; j++) begin
        checks++;
        if (f16(sq_tail, j) != m_tail[j]) begin
          errors++;
          $display("FAIL R7 sq_tail[%0d] actual %0d expected %0d", j, f16(sq_tail, j), m_tail[j]);
        end
        checks++;
        if (f16(cq_head, j) != m_head[j]) begin
          errors++;
          $display("FAIL R4 cq_head[%0d] actual %0d expected %0d", j, f16(cq_head, j), m_head[j]);
        end
        checks++;
        if (sq_kick[j] != m_sqk[j] || cq_kick[j] != m_cqk[j]) begin
          errors++;
          $display("FAIL R8 kick[%0d] actual sq%0b cq%0b expected sq%0b cq%0b",
                   j, sq_kick[j], cq_kick[j], m_sqk[j], m_cqk[j]);
        end
        checks++;
        if (irq[j] != m_irq[j]) begin
          errors++;
          $display("FAIL R9 irq[%0d] actual %0b expected %0b", j, irq[j], m_irq[j]);
        end
      end
    end
  end

  task automatic expect_val(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic db_write(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // queues: sq0..4 present; sq1,sq2 -> cq1; sq3,sq4 -> cq2; cq0..2 present
    sq_ex = NQ'('h1f);
    cq_ex = NQ'('h7);
    sq_sz[0*16 +: 16] = 16; sq_sz[1*16 +: 16] = 8; sq_sz[2*16 +: 16] = 8;
    sq_sz[3*16 +: 16] = 4;  sq_sz[4*16 +: 16] = 4;
    sq_map[1*QW +: QW] = 1; sq_map[2*QW +: QW] = 1;
    sq_map[3*QW +: QW] = 2; sq_map[4*QW +: QW] = 2;
    for (int j = 0; j < 3; j++) cq_sz[j*16 +: 16] = 4;
    cq_tl[1*16 +: 16] = 3;
    cq_tl[2*16 +: 16] = 1;
    cq_tl[0*16 +: 16] = 2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_val("R1 reset tails", longint'(|sq_tail), 0);
    expect_val("R1 reset strobes", longint'(|{sq_kick, cq_kick, irq}), 0);

    db_write('h1008, 32'd3);
    expect_val("R7 sq1 tail", f16(sq_tail, 1), 3);
    expect_val("R7 sq1 kick", longint'(sq_kick), 'h2);
    @(negedge clk);
    expect_val("R7 kick one cycle", longint'(sq_kick), 0);

    db_write('h1008, 32'hABCD0005);
    expect_val("R6 low half used", f16(sq_tail, 1), 5);
    db_write('h1008, 32'd8);
    expect_val("R6 value at size dropped", f16(sq_tail, 1), 5);
    expect_val("R6 no kick", longint'(sq_kick), 0);

    db_write('h100A, 32'd2);
    expect_val("R3 unaligned", f16(sq_tail, 1), 5);
    expect_val("R3 no strobe", longint'(|{sq_kick, cq_kick, irq}), 0);
    db_write('h0008, 32'd2);
    expect_val("R2 below base", f16(sq_tail, 1), 5);
    expect_val("R2 no strobe", longint'(|{sq_kick, cq_kick, irq}), 0);

    db_write('h1028, 32'd1);
    expect_val("R5 absent sq5", longint'(sq_kick), 0);
    db_write('h1200, 32'd1);
    expect_val("R5 index past NUM_Q", longint'(|{sq_kick, cq_kick, irq}), 0);

    db_write('h1010, 32'd6);
    expect_val("R4 sq2 tail", f16(sq_tail, 2), 6);

    // cq1 full (tail 3, head 0): relieve it
    db_write('h100C, 32'd2);
    expect_val("R4 cq1 head", f16(cq_head, 1), 2);
    expect_val("R8 cq kick", longint'(cq_kick), 'h2);
    expect_val("R8 bound sq kicks", longint'(sq_kick), 'h6);
    expect_val("R9 irq cq1", longint'(irq), 'h2);
    db_write('h100C, 32'd3);
    expect_val("R8 not full no wake", longint'(cq_kick | sq_kick), 0);
    expect_val("R9 tail equals head", longint'(irq), 0);
    db_write('h1014, 32'd1);
    expect_val("R9 cq2 no irq", longint'(irq), 0);
    db_write('h1004, 32'd1);
    expect_val("R9 cq0 irq", longint'(irq), 'h1);
    expect_val("R8 cq0 not full", longint'(cq_kick), 0);

    @(negedge clk);
    sq_ex[2] = 1'b0;
    @(negedge clk);
    expect_val("R10 absent sq2 zero", f16(sq_tail, 2), 0);
    sq_ex[2] = 1'b1;

    // random sweep across the window, compared by the model each clock
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 3) != 0);
      addr  = AW'($urandom_range('h0FF0, 'h1240));
      data  = {16'($urandom), 16'($urandom_range(0, 17))};
      if ($urandom_range(0, 7) == 0) begin
        int q;
        q = $urandom_range(0, 2);
        cq_tl[q*16 +: 16] = 16'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 40) == 0) sq_ex[$urandom_range(0, 4)] ^= 1'b1;
      if ($urandom_range(0, 60) == 0) cq_ex[$urandom_range(1, 2)] ^= 1'b1;
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule